// File: doc/BRIEF.md
# Control-Byte Framed Handshake Receiver

This block sits on the receiving side of a byte-oriented serial link and turns a raw byte stream into framed payloads. A frame opens when an enquiry byte is followed at once by a start-of-payload byte. The receiver answers that opening with a ready byte and then stores the payload bytes in a buffer. An end byte closes the frame, and the receiver answers it with an accept byte or a reject byte. Bytes come in, and answers go out, over valid/ready handshakes. The upstream transport can stall either direction.

When a frame closes, the block pulses a done strobe for one cycle. It also gives a verdict flag, the stored length and the buffered bytes, all of which the consumer can read in that cycle. Three things abort the open: a wrong second byte, a payload that runs past the buffer, and a silent link. The link is checked for silence between bytes. The buffer depth and the silence limit are both parameters.

Top module: `ctl_frame_rx`

## Requirements
- R1: After reset, `tx_valid`, `frame_done` and `pay_len` are 0 and `rx_ready` is 1.
- R2: An enquiry byte 0x05 followed by a start byte 0x02 is answered with the ready byte 0x06 on `tx_byte`. `rx_ready` is 0 while any answer is pending.
- R3: After an enquiry byte, any byte other than 0x02 returns the receiver to idle with no answer. A start byte that then arrives alone is ignored.
- R4: In idle, every byte except 0x05 is ignored and draws no answer.
- R5: Payload bytes are stored in arrival order from index 0. Byte k sits at `pay_data[8k+7:8k]`, and `pay_len` counts the stored bytes and never exceeds `MAX_LEN`.
- R6: The end byte 0x04 closes the frame. If no fault occurred, the answer is 0x06 and `frame_done` is high for exactly one cycle with `frame_ok`=1. That cycle is the one in which `tx_valid` rises. An empty payload is accepted.
- R7: A payload byte that arrives while `MAX_LEN` bytes are already stored is discarded and latches an overflow. The frame is then answered with the reject byte 0x15 and `frame_ok`=0, and `pay_len` stays at `MAX_LEN`. The next frame starts clean.
- R8: If a 0x05 or 0x02 byte appears inside the payload, the frame is marked malformed and answered with 0x15.
- R9: While waiting for the start byte or for payload bytes, a gap of `GAP_LIMIT` cycles with no accepted byte aborts the frame back to idle, with no answer. Shorter gaps have no effect.
- R10: An answer holds `tx_valid` high and `tx_byte` unchanged until `tx_ready` takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Receiver takes a byte this cycle |
| tx_byte | output | 8 | Answer byte (ready, accept or reject) |
| tx_valid | output | 1 | Answer pending |
| tx_ready | input | 1 | Answer taken by the transmitter |
| pay_data | output | 8*MAX_LEN | Buffered payload, byte k at bits 8k+7:8k |
| pay_len | output | $clog2(MAX_LEN+1) | Number of stored payload bytes |
| frame_done | output | 1 | One-cycle pulse when a frame closes |
| frame_ok | output | 1 | Verdict of the closed frame (1 = accepted) |

## Verification
The bench sweeps payload lengths from empty to two past a small buffer. A receiver with an off-by-one full test would reject a frame that exactly fills the buffer, or accept one that runs one byte over. It also fails to clear the overflow flag, which would reject the clean frame that follows. Wrong openers are tested: a receiver that stays armed after a bad second byte, or that restarts on a repeated enquiry, would answer a later stray start byte. Control bytes are injected mid-payload, and a receiver that simply stores them would accept a malformed frame. The bench also tests gaps on both sides of the silence limit. A miscounted limit either drops a slow but legal frame or answers a dead one, and a held-off answer that changes value or drops early breaks the output handshake.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

    localparam logic [7:0] BYTE_ENQ = 8'h05;
    localparam logic [7:0] BYTE_STX = 8'h02;
    localparam logic [7:0] BYTE_EOT = 8'h04;
    localparam logic [7:0] BYTE_ACK = 8'h06;
    localparam logic [7:0] BYTE_NAK = 8'h15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPENED,
        ST_READY_OUT,
        ST_BODY,
        ST_VERDICT_OUT
    } rx_state_t;

    function automatic logic is_opener(input logic [7:0] b);
        return (b == BYTE_ENQ) || (b == BYTE_STX);
    endfunction

endpackage

// File: rtl/cfr_gap_timer.sv
module cfr_gap_timer #(
    parameter int GAP_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic kick,
    output logic expire
);
    localparam int CW = $clog2(GAP_LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || kick)
            cnt <= '0;
        else if (cnt != CW'(GAP_LIMIT))
            cnt <= cnt + 1'b1;
    end

    assign expire = run && !kick && (cnt == CW'(GAP_LIMIT - 1));

endmodule

// File: rtl/cfr_payload_store.sv
module cfr_payload_store #(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 wr,
    input  logic [7:0]           wr_byte,
    output logic [8*MAX_LEN-1:0] data_flat,
    output logic [LEN_W-1:0]     len,
    output logic                 overflow
);
    logic full;
    assign full = (len == LEN_W'(MAX_LEN));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            len      <= '0;
            overflow <= 1'b0;
        end else if (wr) begin
            if (full)
                overflow <= 1'b1;
            else
                len <= len + 1'b1;
        end
    end

    for (genvar i = 0; i < MAX_LEN; i++) begin : g_slot
        logic [7:0] slot;
        always_ff @(posedge clk) begin
            if (rst)
                slot <= '0;
            else if (wr && !clear && len == LEN_W'(i))
                slot <= wr_byte;
        end
        assign data_flat[8*i +: 8] = slot;
    end

endmodule

// File: rtl/ctl_frame_rx.sv
module ctl_frame_rx
    import cfr_pkg::*;
#(
    parameter int MAX_LEN   = 16,
    parameter int GAP_LIMIT = 1000,
    localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           rx_byte,
    input  logic                 rx_valid,
    output logic                 rx_ready,
    output logic [7:0]           tx_byte,
    output logic                 tx_valid,
    input  logic                 tx_ready,
    output logic [8*MAX_LEN-1:0] pay_data,
    output logic [LEN_W-1:0]     pay_len,
    output logic                 frame_done,
    output logic                 frame_ok
);
    rx_state_t  state, state_nx;
    logic       take;
    logic       gap_run, gap_expire;
    logic       store_clear, store_wr, store_ovf;
    logic       malformed;
    logic       is_end;
    logic [7:0] answer;

    assign rx_ready = (state == ST_IDLE) || (state == ST_OPENED) || (state == ST_BODY);
    assign take     = rx_valid && rx_ready;
    assign tx_valid = (state == ST_READY_OUT) || (state == ST_VERDICT_OUT);
    assign tx_byte  = answer;
    assign is_end   = (rx_byte == BYTE_EOT);

    assign gap_run     = (state == ST_OPENED) || (state == ST_BODY);
    assign store_clear = (state == ST_OPENED) && take && (rx_byte == BYTE_STX);
    assign store_wr    = (state == ST_BODY) && take && !is_end && !is_opener(rx_byte);

    cfr_gap_timer #(.GAP_LIMIT(GAP_LIMIT)) u_gap (
        .clk    (clk),
        .rst    (rst),
        .run    (gap_run),
        .kick   (take),
        .expire (gap_expire)
    );

    cfr_payload_store #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clear     (store_clear),
        .wr        (store_wr),
        .wr_byte   (rx_byte),
        .data_flat (pay_data),
        .len       (pay_len),
        .overflow  (store_ovf)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:
                if (take && rx_byte == BYTE_ENQ) state_nx = ST_OPENED;
            ST_OPENED:
                if (gap_expire)
                    state_nx = ST_IDLE;
                else if (take)
                    state_nx = (rx_byte == BYTE_STX) ? ST_READY_OUT : ST_IDLE;
            ST_READY_OUT:
                if (tx_ready) state_nx = ST_BODY;
            ST_BODY:
                if (gap_expire)
                    state_nx = ST_IDLE;
                else if (take && is_end)
                    state_nx = ST_VERDICT_OUT;
            ST_VERDICT_OUT:
                if (tx_ready) state_nx = ST_IDLE;
            default:
                state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            answer     <= '0;
            malformed  <= 1'b0;
            frame_done <= 1'b0;
            frame_ok   <= 1'b0;
        end else begin
            state      <= state_nx;
            frame_done <= 1'b0;
            if (store_clear) begin
                malformed <= 1'b0;
                answer    <= BYTE_ACK;
            end
            if (state == ST_BODY && take) begin
                if (is_end) begin
                    frame_done <= 1'b1;
                    frame_ok   <= !(malformed || store_ovf);
                    answer     <= (malformed || store_ovf) ? BYTE_NAK : BYTE_ACK;
                end else if (is_opener(rx_byte)) begin
                    malformed <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cfr_checker.sv
module cfr_checker #(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_ready,
    input logic [7:0]       tx_byte,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [LEN_W-1:0] pay_len,
    input logic             frame_done,
    input logic             frame_ok
);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!tx_valid && !frame_done && pay_len == '0));

    a_r2_stall_while_answer: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !rx_ready);

    a_r5_len_bound: assert property (@(posedge clk) disable iff (rst)
        pay_len <= LEN_W'(MAX_LEN));

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    a_r6_done_with_verdict: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (tx_valid && tx_byte == (frame_ok ? 8'h06 : 8'h15)));

    a_r10_answer_held: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

endmodule

bind ctl_frame_rx cfr_checker #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_ready   (rx_ready),
    .tx_byte    (tx_byte),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .pay_len    (pay_len),
    .frame_done (frame_done),
    .frame_ok   (frame_ok)
);

// File: tb/sim_ctl_frame_rx.sv
`timescale 1ns/1ps
module sim_ctl_frame_rx;
    localparam int MAXL  = 4;
    localparam int GAP   = 16;
    localparam int LW    = $clog2(MAXL + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       rx_byte = '0;
    logic             rx_valid = 1'b0;
    logic             rx_ready;
    logic [7:0]       tx_byte;
    logic             tx_valid;
    logic             tx_ready = 1'b0;
    logic [8*MAXL-1:0] pay_data;
    logic [LW-1:0]    pay_len;
    logic             frame_done;
    logic             frame_ok;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ctl_frame_rx #(.MAX_LEN(MAXL), .GAP_LIMIT(GAP)) u0 (
        .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .tx_byte(tx_byte), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .pay_data(pay_data), .pay_len(pay_len),
        .frame_done(frame_done), .frame_ok(frame_ok)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(8'h40 + seed * 8 + i);
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_answer(input logic [7:0] code, input int hold, input string req);
        int w = 0;
        while (!tx_valid && w < 10) begin
            @(negedge clk);
            w++;
        end
        check(tx_valid === 1'b1 && tx_byte === code, req, tx_byte, code);
        check(rx_ready === 1'b0, "R2 rx_ready during answer", rx_ready, 0);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check(tx_valid === 1'b1 && tx_byte === code, "R10 answer held", tx_byte, code);
        end
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        check(tx_valid === 1'b0, "R10 answer released", tx_valid, 0);
    endtask

    task automatic silent(input int n, input string req);
        bit seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (tx_valid) seen = 1'b1;
        end
        check(!seen, req, seen, 0);
    endtask

    task automatic open_frame();
        send(8'h05);
        send(8'h02);
        expect_answer(8'h06, 0, "R2 ready answer");
    endtask

    task automatic verdict(input bit ok, input int nsent, input int seed, input string req);
        int exp_len = (nsent > MAXL) ? MAXL : nsent;
        check(frame_done === 1'b1, {req, " frame_done"}, frame_done, 1);
        check(frame_ok === ok, {req, " frame_ok"}, frame_ok, ok);
        check(pay_len === LW'(exp_len), "R5 pay_len", pay_len, exp_len);
        for (int i = 0; i < exp_len; i++)
            check(pay_data[8*i +: 8] === pat(seed, i), "R5 byte order", pay_data[8*i +: 8], pat(seed, i));
        expect_answer(ok ? 8'h06 : 8'h15, 0, req);
        check(frame_done === 1'b0, "R6 single pulse", frame_done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(tx_valid === 1'b0 && frame_done === 1'b0, "R1 outputs idle", tx_valid, 0);
        check(rx_ready === 1'b1 && pay_len === '0, "R1 ready and empty", rx_ready, 1);

        // R4: stray bytes in idle
        send(8'h41); send(8'h02); send(8'h04);
        silent(6, "R4 idle ignores non-enquiry");

        // R6/R7 sweep over payload length, empty to two past the buffer
        for (int n = 0; n <= MAXL + 2; n++) begin
            open_frame();
            for (int i = 0; i < n; i++) send(pat(n, i));
            send(8'h04);
            verdict(n <= MAXL, n, n, (n <= MAXL) ? "R6 accept" : "R7 overflow reject");
        end

        // R10: held answer
        send(8'h05); send(8'h02);
        expect_answer(8'h06, 5, "R10 held ready");
        send(pat(1, 0)); send(8'h04);
        verdict(1'b1, 1, 1, "R6 after hold");

        // R3: bad second byte, then lone start byte
        send(8'h05); send(8'h41); send(8'h02);
        silent(6, "R3 bad opener");
        send(8'h05); send(8'h05); send(8'h02);
        silent(6, "R3 repeated enquiry");

        // R8: control bytes inside the payload
        open_frame();
        send(pat(2, 0)); send(8'h05); send(8'h04);
        check(frame_ok === 1'b0, "R8 enquiry in payload", frame_ok, 0);
        expect_answer(8'h15, 0, "R8 reject enquiry");
        open_frame();
        send(8'h02); send(8'h04);
        check(frame_ok === 1'b0, "R8 start in payload", frame_ok, 0);
        expect_answer(8'h15, 0, "R8 reject start");

        // R9: silence aborts, in both waiting states
        open_frame();
        send(pat(3, 0));
        gap(2 * GAP);
        send(8'h04);
        silent(6, "R9 payload gap abort");
        send(8'h05);
        gap(2 * GAP);
        send(8'h02);
        silent(6, "R9 opener gap abort");
        // R9: gap below the limit is harmless
        send(8'h05);
        gap(GAP / 2);
        send(8'h02);
        expect_answer(8'h06, 0, "R9 short gap opener");
        send(pat(4, 0));
        gap(GAP / 2);
        send(pat(4, 1));
        send(8'h04);
        verdict(1'b1, 2, 4, "R9 short gap accept");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule